// File: doc/BRIEF.md
# Dual-Round RC4 Key Scheduler

This block turns a secret key of 1 to 16 bytes into the initial RC4 state: a permutation of the 256 byte values held in a register array. Software or a neighbouring block first fills a small bank of key byte registers through a write port. It then pulses a start input and gives the key length at the same time. The block resets the permutation to the identity over a few cycles. It then runs the 256 scheduling rounds, two dependent rounds in every clock cycle, and pulses done when the last round is complete.

Each cycle executes round `i` and round `i+1`. The second round's j is chained from the first round's j. The two swaps are applied one after the other in the same cycle, so the second round sees the state as the first swap left it, even when the two swaps share entries. The key byte for each round comes from a mux over the key bank. Two running pointers that stay equal to the round index modulo the key length drive that mux, so no 256-entry repeated-key array is built. While the schedule runs, nothing derived from the permutation reaches an output. Once the block is idle, a combinational read port hands the finished permutation to a keystream generator.

Top module: `rc4_ksa_dual`

## Requirements
- R1: After reset, busy_o and done_o are 0 and the permutation is the identity: when idle, rd_data_o equals rd_addr_i.
- R2: A start_i pulse in idle with key_len_i in 1..16 sets busy_o at the next clock edge. The block first rewrites every entry n to n, whatever the previous contents, in DEPTH/INIT_LANES cycles (4 with the defaults), and only then begins the rounds with i = 0 and j = 0.
- R3: The final permutation equals the standard RC4 key schedule: for r = 0..255, j = (j + S[r] + K[r mod l]) mod 256, then S[r] and S[j] swap. This also holds when the two swaps of one cycle share an index, or when one swap's index equals the other round's read index.
- R4: Two rounds complete per cycle: busy_o is high for exactly DEPTH/INIT_LANES + DEPTH/2 cycles (132 with the defaults) after the start edge, and done_o rises in the cycle right after the last busy cycle.
- R5: done_o is a single-cycle pulse. It is high only in the first cycle in which busy_o is low again.
- R6: A start_i pulse while busy_o is high is ignored. It neither restarts nor extends the schedule, and it does not change the result.
- R7: A start_i pulse with key_len_i equal to 0 or greater than 16 is ignored: busy_o stays 0 and the permutation is unchanged.
- R8: When key_we_i is high in idle, key_wdata_i is stored in key byte key_waddr_i (0..15). Key writes while busy_o is high are discarded and do not affect the current schedule or any later one.
- R9: While busy_o is high, rd_data_o is 0. While idle, it shows S[rd_addr_i] in the same cycle.
- R10: Key bytes at an index of l or above, where l is the latched length, never influence the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| key_we_i | input | 1 | Key byte write enable (accepted in idle only) |
| key_waddr_i | input | 4 | Key byte index |
| key_wdata_i | input | 8 | Key byte value |
| key_len_i | input | 5 | Key length in bytes, sampled with start_i; valid range 1..16 |
| start_i | input | 1 | Start pulse |
| busy_o | output | 1 | Initialisation or rounds in progress |
| done_o | output | 1 | One-cycle pulse when the schedule is complete |
| rd_addr_i | input | 8 | Permutation read index |
| rd_data_o | output | 8 | Permutation entry at rd_addr_i; 0 while busy |

## Verification
The bench builds the block with its defaults: 8-bit indices, 16 key slots and 64 entries initialised per cycle. With these values the initialisation takes four cycles, so its block sequencing is exercised, and every key length from 1 to 16 can be reached, including length 1 and length 16, where the key pointers wrap every cycle or never skip. Full 256-entry schedules are compared against a behavioural model. The keys include hand-picked ones that force a self-swap and an overlap between the two swaps in the first cycle, as well as many pseudo-random keys. A known keystream derived from the read-back permutation confirms that the schedule is standard RC4.

// File: rtl/rc4_ksa_pkg.sv
package rc4_ksa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_RUN  = 2'd2
  } ksa_state_e;

  localparam int unsigned N_WR = 4;  // writes per cycle: two swaps
endpackage

// File: rtl/rc4_key_bank.sv
module rc4_key_bank #(
  parameter int ADDR_W  = 8,
  parameter int KEY_MAX = 16,
  localparam int KEY_AW = $clog2(KEY_MAX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [KEY_AW-1:0] waddr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic [KEY_AW-1:0] sel0_i,
  input  logic [KEY_AW-1:0] sel1_i,
  output logic [ADDR_W-1:0] k0_o,
  output logic [ADDR_W-1:0] k1_o
);
  logic [KEY_MAX-1:0][ADDR_W-1:0] key_q;

  for (genvar b = 0; b < KEY_MAX; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) key_q[b] <= '0;
      else if (we_i && waddr_i == KEY_AW'(b)) key_q[b] <= wdata_i;
    end
  end

  // selects are kept below the latched length by the controller
  assign k0_o = key_q[sel0_i];
  assign k1_o = key_q[sel1_i];
endmodule

// File: rtl/rc4_dual_round.sv
module rc4_dual_round #(
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0] s_i,
  input  logic [ADDR_W-1:0]            i_i,
  input  logic [ADDR_W-1:0]            j_i,
  input  logic [ADDR_W-1:0]            k0_i,
  input  logic [ADDR_W-1:0]            k1_i,
  output logic [3:0][ADDR_W-1:0]       wa_o,
  output logic [3:0][ADDR_W-1:0]       wd_o,
  output logic [ADDR_W-1:0]            j_o
);
  logic [ADDR_W-1:0] a0, a1, j1, j2;
  logic [ADDR_W-1:0] s_a0, s_j1, s_a1, s_j2;

  always_comb begin
    a0   = i_i;
    a1   = i_i + ADDR_W'(1);
    s_a0 = s_i[a0];
    j1   = j_i + s_a0 + k0_i;
    s_j1 = s_i[j1];
    // second round reads through the first swap
    s_a1 = (a1 == j1) ? s_a0 : s_i[a1];
    j2   = j1 + s_a1 + k1_i;
    if (j2 == j1)      s_j2 = s_a0;
    else if (j2 == a0) s_j2 = s_j1;
    else               s_j2 = s_i[j2];
    // later writes win over earlier ones in the register array
    wa_o[0] = a0;  wd_o[0] = s_j1;
    wa_o[1] = j1;  wd_o[1] = s_a0;
    wa_o[2] = a1;  wd_o[2] = s_j2;
    wa_o[3] = j2;  wd_o[3] = s_a1;
    j_o = j2;
  end
endmodule

// File: rtl/rc4_sbox_regs.sv
module rc4_sbox_regs #(
  parameter int ADDR_W     = 8,
  parameter int INIT_LANES = 64,
  localparam int DEPTH     = 1 << ADDR_W,
  localparam int INIT_CYC  = DEPTH / INIT_LANES,
  localparam int BLK_W     = (INIT_CYC > 1) ? $clog2(INIT_CYC) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         init_en_i,
  input  logic [BLK_W-1:0]             init_blk_i,
  input  logic                         wr_en_i,
  input  logic [3:0][ADDR_W-1:0]       wa_i,
  input  logic [3:0][ADDR_W-1:0]       wd_i,
  output logic [DEPTH-1:0][ADDR_W-1:0] s_o
);
  for (genvar n = 0; n < DEPTH; n++) begin : g_ent
    logic [ADDR_W-1:0] ent_q, ent_d;

    always_comb begin
      ent_d = ent_q;
      for (int w = 0; w < 4; w++) begin
        if (wa_i[w] == ADDR_W'(n)) ent_d = wd_i[w];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q <= ADDR_W'(n);
      else if (init_en_i && init_blk_i == BLK_W'(n / INIT_LANES)) ent_q <= ADDR_W'(n);
      else if (wr_en_i) ent_q <= ent_d;
    end

    assign s_o[n] = ent_q;
  end
endmodule

// File: rtl/rc4_ksa_ctrl.sv
module rc4_ksa_ctrl
  import rc4_ksa_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int KEY_MAX    = 16,
  parameter int INIT_LANES = 64,
  localparam int DEPTH     = 1 << ADDR_W,
  localparam int KEY_AW    = $clog2(KEY_MAX),
  localparam int LEN_W     = $clog2(KEY_MAX + 1),
  localparam int INIT_CYC  = DEPTH / INIT_LANES,
  localparam int BLK_W     = (INIT_CYC > 1) ? $clog2(INIT_CYC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  key_len_i,
  input  logic [ADDR_W-1:0] j_nxt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              init_en_o,
  output logic [BLK_W-1:0]  init_blk_o,
  output logic              step_en_o,
  output logic [ADDR_W-1:0] i_o,
  output logic [ADDR_W-1:0] j_o,
  output logic [KEY_AW-1:0] kp0_o,
  output logic [KEY_AW-1:0] kp1_o
);
  localparam int TW = LEN_W + 1;

  ksa_state_e        state_q;
  logic [BLK_W-1:0]  blk_q;
  logic [ADDR_W-1:0] i_q, j_q;
  logic [KEY_AW-1:0] kp0_q, kp1_q;
  logic [LEN_W-1:0]  len_q;
  logic              done_q;
  logic              len_ok;

  // advance a key pointer by two, modulo len (len >= 1)
  function automatic logic [KEY_AW-1:0] adv2(logic [KEY_AW-1:0] kp, logic [LEN_W-1:0] len);
    logic [TW-1:0] t;
    t = TW'(kp) + TW'(2);
    if (t >= TW'(len)) t = t - TW'(len);
    if (t >= TW'(len)) t = t - TW'(len);
    return t[KEY_AW-1:0];
  endfunction

  assign len_ok = (key_len_i != '0) && (key_len_i <= LEN_W'(KEY_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      blk_q   <= '0;
      i_q     <= '0;
      j_q     <= '0;
      kp0_q   <= '0;
      kp1_q   <= '0;
      len_q   <= LEN_W'(1);
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && len_ok) begin
            state_q <= ST_INIT;
            blk_q   <= '0;
            len_q   <= key_len_i;
          end
        end
        ST_INIT: begin
          blk_q <= blk_q + BLK_W'(1);
          if (blk_q == BLK_W'(INIT_CYC - 1)) begin
            state_q <= ST_RUN;
            i_q     <= '0;
            j_q     <= '0;
            kp0_q   <= '0;
            kp1_q   <= KEY_AW'(len_q != LEN_W'(1));
          end
        end
        ST_RUN: begin
          i_q   <= i_q + ADDR_W'(2);
          j_q   <= j_nxt_i;
          kp0_q <= adv2(kp0_q, len_q);
          kp1_q <= adv2(kp1_q, len_q);
          if (i_q == ADDR_W'(DEPTH - 2)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign init_en_o  = (state_q == ST_INIT);
  assign init_blk_o = blk_q;
  assign step_en_o  = (state_q == ST_RUN);
  assign i_o        = i_q;
  assign j_o        = j_q;
  assign kp0_o      = kp0_q;
  assign kp1_o      = kp1_q;
endmodule

// File: rtl/rc4_ksa_dual.sv
module rc4_ksa_dual #(
  parameter int ADDR_W     = 8,
  parameter int KEY_MAX    = 16,
  parameter int INIT_LANES = 64,
  localparam int DEPTH     = 1 << ADDR_W,
  localparam int KEY_AW    = $clog2(KEY_MAX),
  localparam int LEN_W     = $clog2(KEY_MAX + 1),
  localparam int INIT_CYC  = DEPTH / INIT_LANES,
  localparam int BLK_W     = (INIT_CYC > 1) ? $clog2(INIT_CYC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_we_i,
  input  logic [KEY_AW-1:0] key_waddr_i,
  input  logic [ADDR_W-1:0] key_wdata_i,
  input  logic [LEN_W-1:0]  key_len_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [ADDR_W-1:0] rd_data_o
);
  logic                         busy, init_en, step_en;
  logic [BLK_W-1:0]             init_blk;
  logic [ADDR_W-1:0]            i_cur, j_cur, j_nxt, k0, k1;
  logic [KEY_AW-1:0]            kp0, kp1;
  logic [3:0][ADDR_W-1:0]       wa, wd;
  logic [DEPTH-1:0][ADDR_W-1:0] s_all;

  rc4_ksa_ctrl #(
    .ADDR_W(ADDR_W), .KEY_MAX(KEY_MAX), .INIT_LANES(INIT_LANES)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .key_len_i  (key_len_i),
    .j_nxt_i    (j_nxt),
    .busy_o     (busy),
    .done_o     (done_o),
    .init_en_o  (init_en),
    .init_blk_o (init_blk),
    .step_en_o  (step_en),
    .i_o        (i_cur),
    .j_o        (j_cur),
    .kp0_o      (kp0),
    .kp1_o      (kp1)
  );

  rc4_key_bank #(.ADDR_W(ADDR_W), .KEY_MAX(KEY_MAX)) u_keys (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (key_we_i && !busy),
    .waddr_i (key_waddr_i),
    .wdata_i (key_wdata_i),
    .sel0_i  (kp0),
    .sel1_i  (kp1),
    .k0_o    (k0),
    .k1_o    (k1)
  );

  rc4_dual_round #(.ADDR_W(ADDR_W)) u_round (
    .s_i  (s_all),
    .i_i  (i_cur),
    .j_i  (j_cur),
    .k0_i (k0),
    .k1_i (k1),
    .wa_o (wa),
    .wd_o (wd),
    .j_o  (j_nxt)
  );

  rc4_sbox_regs #(.ADDR_W(ADDR_W), .INIT_LANES(INIT_LANES)) u_sbox (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_en_i  (init_en),
    .init_blk_i (init_blk),
    .wr_en_i    (step_en),
    .wa_i       (wa),
    .wd_i       (wd),
    .s_o        (s_all)
  );

  assign busy_o    = busy;
  // state is kept off the output while scheduling
  assign rd_data_o = busy ? '0 : s_all[rd_addr_i];
endmodule

// File: rtl/rc4_ksa_dual_chk.sv
module rc4_ksa_dual_chk #(
  parameter int ADDR_W     = 8,
  parameter int KEY_MAX    = 16,
  parameter int INIT_LANES = 64,
  localparam int DEPTH     = 1 << ADDR_W,
  localparam int LEN_W     = $clog2(KEY_MAX + 1),
  localparam int TOTAL     = DEPTH / INIT_LANES + DEPTH / 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [LEN_W-1:0]  key_len_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [ADDR_W-1:0] rd_data_o
);
  int unsigned busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt <= 0;
    else if (busy_o) busy_cnt <= busy_cnt + 1;
    else busy_cnt <= 0;
  end

  p_done_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_cnt == TOTAL));

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_len_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(key_len_i) != '0 && $past(key_len_i) <= LEN_W'(KEY_MAX)));

  p_hidden_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (rd_data_o == '0));

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o) && $stable(rd_addr_i)) |-> $stable(rd_data_o));
endmodule

bind rc4_ksa_dual rc4_ksa_dual_chk #(
  .ADDR_W(ADDR_W), .KEY_MAX(KEY_MAX), .INIT_LANES(INIT_LANES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .key_len_i (key_len_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o)
);

// File: tb/rc4_ksa_dual_tb_top.sv
module rc4_ksa_dual_tb_top;
  localparam int TOTAL = 256 / 64 + 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_we = 1'b0;
  logic [3:0] key_waddr = '0;
  logic [7:0] key_wdata = '0;
  logic [4:0] key_len = 5'd1;
  logic       start = 1'b0;
  logic       busy, done;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  int kref[16];
  int sref[256];
  int sdut[256];
  int seed = 32'h1234_5678;

  always #5 clk = ~clk;

  rc4_ksa_dual dut_i (
    .clk_i(clk), .rst_ni(rst_n), .key_we_i(key_we), .key_waddr_i(key_waddr),
    .key_wdata_i(key_wdata), .key_len_i(key_len), .start_i(start),
    .busy_o(busy), .done_o(done), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    end
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'hff;
  endfunction

  task automatic model_ksa(input int len);
    int j = 0;
    int t;
    for (int n = 0; n < 256; n++) sref[n] = n;
    for (int r = 0; r < 256; r++) begin
      j = (j + sref[r] + kref[r % len]) % 256;
      t = sref[r]; sref[r] = sref[j]; sref[j] = t;
    end
  endtask

  task automatic write_key(input int idx, input int val);
    @(negedge clk);
    key_we = 1'b1; key_waddr = 4'(idx); key_wdata = 8'(val);
    @(negedge clk);
    key_we = 1'b0;
  endtask

  task automatic load_key(input int len);
    for (int b = 0; b < len; b++) write_key(b, kref[b]);
  endtask

  task automatic read_all();
    for (int a = 0; a < 256; a++) begin
      rd_addr = 8'(a);
      #1;
      sdut[a] = int'(rd_data);
    end
  endtask

  task automatic cmp_all(input string req);
    int bad = -1;
    read_all();
    for (int a = 0; a < 256; a++) if (bad < 0 && sdut[a] != sref[a]) bad = a;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, sdut[bad], sref[bad]);
  endtask

  // start and run one schedule, checking busy/done on every cycle
  task automatic run_ksa(input int len, input bit poke_start, input bit poke_key);
    @(negedge clk);
    key_len = 5'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < TOTAL; c++) begin
      start = poke_start && (c == 50);
      key_len = poke_start && (c == 50) ? 5'd3 : 5'(len);
      key_we = poke_key && (c == 60);
      key_waddr = 4'd0; key_wdata = 8'(kref[0] ^ 8'h5a);
      rd_addr = 8'(c * 7);
      #1;
      chk(busy == 1'b1 && done == 1'b0, poke_start ? "R6 busy window" : "R4 busy window",
          {busy, done}, 2);
      if (c == 0) chk(busy == 1'b1, "R2 busy rises", busy, 1);
      if (c % 16 == 3) chk(rd_data == 8'd0, "R9 hidden while busy", rd_data, 0);
      @(negedge clk);
    end
    start = 1'b0; key_we = 1'b0; key_len = 5'(len);
    #1;
    chk(busy == 1'b0 && done == 1'b1, "R4 done after 132 cycles", {busy, done}, 1);
    @(negedge clk);
    #1;
    chk(done == 1'b0, "R5 done single cycle", done, 0);
  endtask

  initial begin
    int ks[10];
    int ii, jj, t;
    int len;
    ks = '{8'heb, 8'h9f, 8'h77, 8'h81, 8'hb7, 8'h34, 8'hca, 8'h72, 8'ha7, 8'h19};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(busy == 1'b0 && done == 1'b0, "R1 reset flags", {busy, done}, 0);
    for (int a = 0; a < 256; a++) sref[a] = a;
    cmp_all("R1 identity after reset");

    // known vector: key "Key"
    kref[0] = 8'h4b; kref[1] = 8'h65; kref[2] = 8'h79;
    load_key(3);
    run_ksa(3, 1'b0, 1'b0);
    model_ksa(3);
    cmp_all("R3 key Key");
    ii = 0; jj = 0;
    for (int n = 0; n < 10; n++) begin
      ii = (ii + 1) % 256;
      jj = (jj + sdut[ii]) % 256;
      t = sdut[ii]; sdut[ii] = sdut[jj]; sdut[jj] = t;
      chk(sdut[(sdut[ii] + sdut[jj]) % 256] == ks[n], "R3 keystream",
          sdut[(sdut[ii] + sdut[jj]) % 256], ks[n]);
    end

    // R10: byte beyond length must not matter
    write_key(7, 8'hc3);
    run_ksa(3, 1'b0, 1'b0);
    cmp_all("R10 unused key byte");

    // R6: start while busy; R8: key write while busy
    run_ksa(3, 1'b1, 1'b1);
    cmp_all("R6 R8 result unchanged");
    run_ksa(3, 1'b0, 1'b0);
    cmp_all("R8 discarded write stays discarded");

    // R7: illegal lengths
    for (int v = 0; v < 2; v++) begin
      @(negedge clk);
      key_len = (v == 0) ? 5'd0 : 5'd17; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 4; c++) begin
        #1;
        chk(busy == 1'b0 && done == 1'b0, "R7 bad length ignored", {busy, done}, 0);
        @(negedge clk);
      end
      cmp_all("R7 state unchanged");
    end

    // corner keys: self-swap, first-cycle overlap, all ones full length
    kref[0] = 0;
    load_key(1);
    run_ksa(1, 1'b0, 1'b0);
    model_ksa(1);
    cmp_all("R3 len1 zero key");
    kref[0] = 1; kref[1] = 0;
    load_key(2);
    run_ksa(2, 1'b0, 1'b0);
    model_ksa(2);
    cmp_all("R3 overlap key");
    for (int b = 0; b < 16; b++) kref[b] = 8'hff;
    load_key(16);
    run_ksa(16, 1'b0, 1'b0);
    model_ksa(16);
    cmp_all("R2 R3 len16 reinit");

    // pseudo-random keys, every length
    for (int k = 0; k < 16; k++) begin
      len = k + 1;
      for (int b = 0; b < 16; b++) kref[b] = rnd();
      load_key(16);
      run_ksa(len, 1'b0, 1'b0);
      model_ksa(len);
      cmp_all("R3 R10 random key");
    end

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end
endmodule